// File: doc/BRIEF.md
# Interrupt Distributor Configuration Bank

This block is the register bank and state store behind an interrupt distributor. It keeps, for each of `NUM_LINES` interrupt IDs (a multiple of 32), an enable bit, a pending bit, an active bit, an 8-bit priority, an 8-bit CPU-target mask and a 2-bit trigger configuration. Software reaches all of it through a simple word-wide register port with byte strobes. Each one-bit state has two views: a write-1-to-set view and a write-1-to-clear view. Either view reads back the current state.

Interrupt lines come in on `lineIn`. A line configured as edge-triggered latches pending on a rising edge, and the bit stays set until software clears it. A line configured as level-sensitive shows pending for as long as it is high. A global enable bit gates the `fwdIrq` vector. That vector marks every ID that is pending, enabled and allowed to go on to the selection stage. Picking the winning interrupt and delivering it to processors belong to later stages.

IDs 0–15 are the software-generated class, IDs 16–31 are per-processor and IDs from 32 upward are shared. The target masks of IDs below 32 cannot be written. A type register reports the implemented line count and CPU count. Reads from offsets beyond the implemented line count return zero, and writes to them are dropped. Addresses are word addresses (`addr[1:0]` is ignored). Byte access uses `wrStrb`.

Top module: `irqDistBank`

## Requirements
- R1: After reset, every enable, pending, active, priority, target and configuration field is zero, the global enable is 0, and `fwdIrq` is all zero.
- R2: A read at 0x004 returns bits 4:0 = NUM_LINES/32 − 1 and bits 7:5 = NUM_CPUS − 1, with all other bits zero (0x61 for 64 lines and 4 CPUs).
- R3: Bit 0 at 0x000 is the global enable and reads back. `fwdIrq[n]` is 1 exactly when ID n is pending and enabled and the global enable is 1.
- R4: Writing 1s at 0x100 + 4×(n/32) sets enable bits, and writing 1s at 0x180 + 4×(n/32) clears them. Bit n%32 of the data word addresses ID n, and 0 bits change nothing. Both offsets read the enable state.
- R5: Pending bits follow the same set/clear pairing at 0x200 and 0x280, and active bits follow it at 0x300 and 0x380.
- R6: The priority of ID n is the byte at 0x400 + n. Within a word, ID 4k+b sits in bits 8b+7:8b.
- R7: The target mask of ID n is the byte at 0x800 + n, with the same byte layout as R6. Writes to the targets of IDs 0–31 have no effect, and those fields read as zero.
- R8: The configuration of ID n is held in bits 2(n%16)+1:2(n%16) of the word at 0xC00 + 4×(n/16). The upper bit of each field selects edge (1) or level (0). The lower bit is stored but has no effect.
- R9: For an edge-configured ID, a rising edge on its line sets pending. The bit stays set after the line falls and goes away only through a clear-pending write.
- R10: For a level-configured ID, pending reads 1 while the line is high, even after a clear-pending write. It reads 0 once the line is low and no set-pending write is latched.
- R11: Enable, pending and active words at or beyond NUM_LINES/32, priority and target bytes at or beyond NUM_LINES, and configuration words at or beyond NUM_LINES/16 read as zero and ignore writes.
- R12: Only the bytes whose `wrStrb` bit is 1 are written. This applies to every register, and a write with all strobes at zero changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the current address |
| addr | input | 12 | Byte offset of the accessed word (bits 1:0 ignored) |
| wrData | input | 32 | Write data |
| wrStrb | input | 4 | Byte write enables |
| lineIn | input | NUM_LINES | Interrupt input lines, one per ID |
| rdData | output | 32 | Combinational read data for `addr` |
| fwdIrq | output | NUM_LINES | IDs that are pending, enabled and globally forwarded |

## Verification
The hardest condition to reach from the ports is one pending bit made of two sources at once: a level line that is held high, and a latched set or edge event. The bench configures one ID as edge-triggered through its configuration word. It then raises and lowers that ID's line and shows that pending persists until a clear-pending write. On a neighbouring level ID, it holds the line high across a clear-pending write and then releases the line, so the read-back shows that a clear cannot hide an asserted level.

// File: rtl/irqDistPkg.sv
package irqDistPkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_TYPE,
    SEL_EN,
    SEL_PEND,
    SEL_ACT,
    SEL_PRIO,
    SEL_TGT,
    SEL_CFG
  } regSel_e;

  // Decoded access passed from the decoder to the state datapath
  typedef struct packed {
    logic    wr;   // write this cycle
    logic    clr;  // clear view of a set/clear pair
    regSel_e sel;  // addressed region (SEL_NONE when out of range)
    logic [7:0] idx; // word index inside the region
  } regStrobe_t;

endpackage

// File: rtl/irqDistDecode.sv
module irqDistDecode
  import irqDistPkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic        wrEn,
  input  logic [11:0] addr,
  output regStrobe_t  strobe
);
  localparam int BIT_WORDS  = NUM_LINES / 32;
  localparam int BYTE_WORDS = NUM_LINES / 4;
  localparam int CFG_WORDS  = NUM_LINES / 16;

  always_comb begin
    strobe     = '0;
    strobe.wr  = wrEn;
    strobe.clr = addr[7];
    strobe.sel = SEL_NONE;
    if (addr[11:2] == 10'd0) begin
      strobe.sel = SEL_CTRL;
    end else if (addr[11:2] == 10'd1) begin
      strobe.sel = SEL_TYPE;
    end else if (addr[11:8] inside {4'h1, 4'h2, 4'h3}) begin
      if (32'(addr[6:2]) < BIT_WORDS) begin
        strobe.idx = {3'b0, addr[6:2]};
        case (addr[9:8])
          2'd1:    strobe.sel = SEL_EN;
          2'd2:    strobe.sel = SEL_PEND;
          default: strobe.sel = SEL_ACT;
        endcase
      end
    end else if (addr[11:10] == 2'b01 || addr[11:10] == 2'b10) begin
      if (32'(addr[9:2]) < BYTE_WORDS) begin
        strobe.idx = addr[9:2];
        strobe.sel = addr[11] ? SEL_TGT : SEL_PRIO;
      end
    end else if (addr[11:8] == 4'hC) begin
      if (32'(addr[7:2]) < CFG_WORDS) begin
        strobe.idx = {2'b0, addr[7:2]};
        strobe.sel = SEL_CFG;
      end
    end
  end
endmodule

// File: rtl/irqDistState.sv
module irqDistState
  import irqDistPkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPUS  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strobe,
  input  logic [31:0]          wrData,
  input  logic [3:0]           wrStrb,
  input  logic [NUM_LINES-1:0] lineIn,
  output logic [31:0]          rdData,
  output logic                 ctrlEn,
  output logic [NUM_LINES-1:0] enVec,
  output logic [NUM_LINES-1:0] pendVec,
  output logic [NUM_LINES-1:0] fwdIrq
);
  localparam int BIT_WORDS  = NUM_LINES / 32;
  localparam int BYTE_WORDS = NUM_LINES / 4;
  localparam int CFG_WORDS  = NUM_LINES / 16;
  localparam int FIRST_SHARED = 32;
  localparam logic [31:0] TYPE_WORD =
    {24'b0, 3'(NUM_CPUS - 1), 5'(BIT_WORDS - 1)};

  logic [NUM_LINES-1:0]      pendLatch, actVec, linePrev, edgeMask, riseVec;
  logic [NUM_LINES-1:0]      enNext, pendNext, actNext;
  logic [NUM_LINES-1:0][7:0] prio, tgt;
  logic [NUM_LINES-1:0][1:0] cfg;
  logic [31:0]               wm;

  assign wm = wrData & {{8{wrStrb[3]}}, {8{wrStrb[2]}}, {8{wrStrb[1]}}, {8{wrStrb[0]}}};

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) edgeMask[i] = cfg[i][1];
  end

  assign riseVec = lineIn & ~linePrev & edgeMask;
  assign pendVec = pendLatch | (lineIn & ~edgeMask);
  assign fwdIrq  = pendVec & enVec & {NUM_LINES{ctrlEn}};

  // Set/clear views of the one-bit state
  always_comb begin
    enNext   = enVec;
    pendNext = pendLatch | riseVec;
    actNext  = actVec;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (strobe.wr && strobe.idx == 8'(i / 32)) begin
        if (strobe.sel == SEL_EN)
          enNext[i] = strobe.clr ? (enNext[i] & ~wm[i % 32]) : (enNext[i] | wm[i % 32]);
        if (strobe.sel == SEL_PEND)
          pendNext[i] = strobe.clr ? (pendNext[i] & ~wm[i % 32]) : (pendNext[i] | wm[i % 32]);
        if (strobe.sel == SEL_ACT)
          actNext[i] = strobe.clr ? (actNext[i] & ~wm[i % 32]) : (actNext[i] | wm[i % 32]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn    <= 1'b0;
      enVec     <= '0;
      pendLatch <= '0;
      actVec    <= '0;
      linePrev  <= '0;
      prio      <= '0;
      tgt       <= '0;
      cfg       <= '0;
    end else begin
      linePrev  <= lineIn;
      enVec     <= enNext;
      pendLatch <= pendNext;
      actVec    <= actNext;
      if (strobe.wr && strobe.sel == SEL_CTRL && wrStrb[0]) ctrlEn <= wrData[0];
      for (int i = 0; i < NUM_LINES; i++) begin
        if (strobe.wr && strobe.idx == 8'(i / 4) && wrStrb[i % 4]) begin
          if (strobe.sel == SEL_PRIO) prio[i] <= wrData[8*(i%4) +: 8];
          if (strobe.sel == SEL_TGT && i >= FIRST_SHARED) tgt[i] <= wrData[8*(i%4) +: 8];
        end
        if (strobe.wr && strobe.sel == SEL_CFG && strobe.idx == 8'(i / 16) &&
            wrStrb[(i % 16) / 4])
          cfg[i] <= wrData[2*(i%16) +: 2];
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (strobe.sel)
      SEL_CTRL: rdData = {31'b0, ctrlEn};
      SEL_TYPE: rdData = TYPE_WORD;
      SEL_EN, SEL_PEND, SEL_ACT: begin
        for (int w = 0; w < BIT_WORDS; w++) begin
          if (strobe.idx == 8'(w)) begin
            if (strobe.sel == SEL_EN)        rdData = enVec[w*32 +: 32];
            else if (strobe.sel == SEL_PEND) rdData = pendVec[w*32 +: 32];
            else                             rdData = actVec[w*32 +: 32];
          end
        end
      end
      SEL_PRIO, SEL_TGT: begin
        for (int w = 0; w < BYTE_WORDS; w++) begin
          if (strobe.idx == 8'(w))
            rdData = (strobe.sel == SEL_PRIO) ? prio[w*4 +: 4] : tgt[w*4 +: 4];
        end
      end
      SEL_CFG: begin
        for (int w = 0; w < CFG_WORDS; w++) begin
          if (strobe.idx == 8'(w)) rdData = cfg[w*16 +: 16];
        end
      end
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/irqDistBank.sv
module irqDistBank
  import irqDistPkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPUS  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [11:0]          addr,
  input  logic [31:0]          wrData,
  input  logic [3:0]           wrStrb,
  input  logic [NUM_LINES-1:0] lineIn,
  output logic [31:0]          rdData,
  output logic [NUM_LINES-1:0] fwdIrq
);
  regStrobe_t           strobe;
  logic                 ctrlEn;
  logic [NUM_LINES-1:0] enVec, pendVec;

  irqDistDecode #(.NUM_LINES(NUM_LINES)) i_decode (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe)
  );

  irqDistState #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS)) i_state (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .wrStrb  (wrStrb),
    .lineIn  (lineIn),
    .rdData  (rdData),
    .ctrlEn  (ctrlEn),
    .enVec   (enVec),
    .pendVec (pendVec),
    .fwdIrq  (fwdIrq)
  );
endmodule

// File: rtl/irqDistBankChk.sv
module irqDistBankChk #(
  parameter int NUM_LINES = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [11:0]          addr,
  input logic [3:0]           wrStrb,
  input logic                 ctrlEn,
  input logic [NUM_LINES-1:0] enVec,
  input logic [NUM_LINES-1:0] pendVec,
  input logic [NUM_LINES-1:0] fwdIrq
);
  // R3
  fwd_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fwdIrq & ~(enVec & pendVec)) == '0 && (ctrlEn || fwdIrq == '0));

  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(enVec));

  // R4
  en_set_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[11:7] == 5'b00010) |=> ((~enVec & $past(enVec)) == '0));

  // R4
  en_clr_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[11:7] == 5'b00011) |=> ((enVec & ~$past(enVec)) == '0));

  // R12
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrStrb == 4'b0000) |=> ($stable(ctrlEn) && $stable(enVec)));
endmodule

bind irqDistBank irqDistBankChk #(.NUM_LINES(NUM_LINES)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrStrb  (wrStrb),
  .ctrlEn  (ctrlEn),
  .enVec   (enVec),
  .pendVec (pendVec),
  .fwdIrq  (fwdIrq)
);

// File: tb/test_irqDistBank.sv
`timescale 1ns/1ps
module test_irqDistBank;
  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wrData = '0;
  logic [3:0]    wrStrb = '0;
  logic [N-1:0]  lineIn = '0;
  logic [31:0]   rdData;
  logic [N-1:0]  fwdIrq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irqDistBank #(.NUM_LINES(N), .NUM_CPUS(4)) i_irqDistBank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .wrStrb(wrStrb), .lineIn(lineIn), .rdData(rdData), .fwdIrq(fwdIrq)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    addr = a; wrData = d; wrStrb = s; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrStrb = '0;
  endtask

  task automatic rdChk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, 64'(rdData), 64'(exp));
  endtask

  task automatic t_reset();
    rdChk("R1 ctrl", 12'h000, 32'h0);
    rdChk("R1 enable", 12'h100, 32'h0);
    rdChk("R1 priority", 12'h420, 32'h0);
    rdChk("R1 config", 12'hC08, 32'h0);
    check("R1 fwdIrq", 64'(fwdIrq), 64'h0);
    rdChk("R2 type", 12'h004, 32'h61);
  endtask

  task automatic t_enable();
    wr(12'h100, 32'h0000_00F0, 4'hF);
    rdChk("R4 set view", 12'h100, 32'hF0);
    rdChk("R4 clear view read", 12'h180, 32'hF0);
    wr(12'h180, 32'h0000_0030, 4'hF);
    rdChk("R4 clear", 12'h100, 32'hC0);
    wr(12'h100, 32'h0, 4'hF);
    rdChk("R4 zero bits", 12'h100, 32'hC0);
  endtask

  task automatic t_pendAct();
    wr(12'h204, 32'h1, 4'hF);
    rdChk("R5 pend set", 12'h204, 32'h1);
    rdChk("R5 pend clear view read", 12'h284, 32'h1);
    wr(12'h284, 32'h1, 4'hF);
    rdChk("R5 pend clear", 12'h204, 32'h0);
    wr(12'h300, 32'h5, 4'hF);
    rdChk("R5 active set", 12'h300, 32'h5);
    wr(12'h380, 32'h1, 4'hF);
    rdChk("R5 active clear", 12'h380, 32'h4);
  endtask

  task automatic t_forward();
    wr(12'h104, 32'h2, 4'hF);
    wr(12'h204, 32'h2, 4'hF);
    #1 check("R3 gated off", 64'(fwdIrq), 64'h0);
    wr(12'h000, 32'h1, 4'hF);
    rdChk("R3 ctrl readback", 12'h000, 32'h1);
    check("R3 forwarded", 64'(fwdIrq), 64'h2 << 32);
    wr(12'h000, 32'h0, 4'h0);
    rdChk("R12 no strobe", 12'h000, 32'h1);
    wr(12'h184, 32'h2, 4'hF);
    #1 check("R3 disabled id", 64'(fwdIrq), 64'h0);
    wr(12'h284, 32'h2, 4'hF);
  endtask

  task automatic t_prio();
    wr(12'h420, 32'h4433_2211, 4'hF);
    rdChk("R6 priority word", 12'h420, 32'h4433_2211);
    wr(12'h420, 32'h00AA_0000, 4'b0100);
    rdChk("R12 priority byte", 12'h420, 32'h44AA_2211);
  endtask

  task automatic t_target();
    wr(12'h800, 32'hFFFF_FFFF, 4'hF);
    rdChk("R7 sgi target ignored", 12'h800, 32'h0);
    wr(12'h81C, 32'h0F0F_0F0F, 4'hF);
    rdChk("R7 ppi target ignored", 12'h81C, 32'h0);
    wr(12'h820, 32'h0F0E_0D0C, 4'hF);
    rdChk("R7 shared target", 12'h820, 32'h0F0E_0D0C);
  endtask

  task automatic t_edgeLevel();
    wr(12'hC08, 32'h2, 4'b0001);
    rdChk("R8 config readback", 12'hC08, 32'h2);
    @(negedge clk); lineIn[32] = 1'b1;
    rdChk("R9 edge latched", 12'h204, 32'h1);
    @(negedge clk); lineIn[32] = 1'b0;
    rdChk("R9 edge held", 12'h204, 32'h1);
    wr(12'h284, 32'h1, 4'hF);
    rdChk("R9 edge cleared", 12'h204, 32'h0);
    @(negedge clk); lineIn[34] = 1'b1;
    rdChk("R10 level high", 12'h204, 32'h4);
    wr(12'h284, 32'h4, 4'hF);
    rdChk("R10 clear while high", 12'h204, 32'h4);
    @(negedge clk); lineIn[34] = 1'b0;
    rdChk("R10 level low", 12'h204, 32'h0);
  endtask

  task automatic t_outOfRange();
    wr(12'h108, 32'hFFFF_FFFF, 4'hF);
    rdChk("R11 enable word", 12'h108, 32'h0);
    wr(12'h440, 32'hFFFF_FFFF, 4'hF);
    rdChk("R11 priority byte", 12'h440, 32'h0);
    wr(12'hC10, 32'hFFFF_FFFF, 4'hF);
    rdChk("R11 config word", 12'hC10, 32'h0);
    rdChk("R11 in-range neighbour", 12'h104, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_enable();
    t_pendAct();
    t_forward();
    t_prio();
    t_target();
    t_edgeLevel();
    t_outOfRange();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule